// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Table

This block is a configurable logic element for a programmable fabric. A 64-entry truth table is held outside the block and presented as a parallel vector. The six logic inputs act as the select lines of a binary multiplexer tree, and the truth-table bits are the leaves of that tree. The block has no clock and no storage, so every output is a combinational function of the current inputs. How the configuration is loaded is outside its scope.

A single mode bit sets how the table is used. With the mode bit low, the block is one full six-input function. With the mode bit high, the top logic input is held at logic one through an OR gate, and the two nodes one level below the root become two independent five-input functions. Each of those functions uses half of the table, and they share the five lower inputs. The two fifth-level nodes are always brought out, so the fractured outputs can be read in either mode. The unconfigured value of the mode bit is 1, which places the element in dual mode until it is programmed otherwise.

Top module: `lut6_frac`

## Requirements
- R1: With `modeSel`=0, `lut6Out` equals `truthTable[idx]`, where idx is `lutIn` read as an unsigned number with `lutIn[0]` as its least significant bit.
- R2: In both modes, `lut5Out[0]` equals `truthTable[lutIn[4:0]]`, the function formed by table bits 0 to 31.
- R3: In both modes, `lut5Out[1]` equals `truthTable[32 + lutIn[4:0]]`, the function formed by table bits 32 to 63.
- R4: With `modeSel`=1 (dual mode, which is the unconfigured value), `lut6Out` equals `lut5Out[1]`, and `lutIn[5]` has no effect on any output.
- R5: With `modeSel`=0, `lutIn[5]`=0 makes `lut6Out` follow `lut5Out[0]`, and `lutIn[5]`=1 makes it follow `lut5Out[1]`.
- R6: The path is purely combinational. A change on any input is visible at the outputs in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lutIn | input | 6 | Logic inputs. Bit 0 selects at the stage nearest the leaves. |
| truthTable | input | 64 | Configuration bits. Bit i is the function value for index i. |
| modeSel | input | 1 | 1 = two five-input functions, 0 = one six-input function. |
| lut5Out | output | 2 | Outputs of the two fifth-level nodes (lower half, upper half). |
| lut6Out | output | 1 | Output of the root of the tree. |

## Verification
A select line that is wrongly gated, or a tree stage that reads the wrong half of its level, shows at the ports as soon as the inputs change. Because the path holds no state, a fault cannot hide for later cycles; it appears on the address that reaches the bad node. For this reason every one of the 64 addresses is applied in both modes, against tables that are patterned, random and one-hot. This exposes each leaf and each intermediate node at least once with a value that differs from its sibling. Dual mode is also swept with the top input toggling, so that a leak of `lutIn[5]` through the gate shows as a difference between paired addresses.

// File: rtl/lut6_frac_pkg.sv
package lut6_frac_pkg;
  // number of logic inputs (tree depth)
  localparam int LUT_INPUTS = 6;
  // tree level whose nodes are brought out as the fractured outputs
  localparam int FRAC_LEVEL = 5;
  // derived sizes
  localparam int LEAVES = 1 << LUT_INPUTS;
  localparam int TAPS   = 1 << (LUT_INPUTS - FRAC_LEVEL);

  // strobes from mode control to the tree datapath
  typedef struct packed {
    logic                  dualMode;
    logic [LUT_INPUTS-1:0] selLines;
  } lut_strobe_t;
endpackage

// File: rtl/lut_mode_ctrl.sv
module lut_mode_ctrl
  import lut6_frac_pkg::*;
(
  input  logic [LUT_INPUTS-1:0] lutIn,
  input  logic                  modeSel,
  output lut_strobe_t           strobe
);
  logic [LUT_INPUTS-1:0] gatedSel;

  // inputs above the fracture level are forced high by the mode bit
  for (genvar k = 0; k < LUT_INPUTS; k++) begin : gSel
    if (k >= FRAC_LEVEL) begin : gForced
      assign gatedSel[k] = lutIn[k] | modeSel;
    end else begin : gPlain
      assign gatedSel[k] = lutIn[k];
    end
  end

  assign strobe = '{dualMode: modeSel, selLines: gatedSel};
endmodule

// File: rtl/lut_mux_tree.sv
module lut_mux_tree
  import lut6_frac_pkg::*;
(
  input  logic [LEAVES-1:0] truthTable,
  input  lut_strobe_t       strobe,
  output logic [TAPS-1:0]   fracTaps,
  output logic              fullOut
);
  for (genvar lv = 0; lv <= LUT_INPUTS; lv++) begin : gLevel
    localparam int W = LEAVES >> lv;
    logic [W-1:0] node;
    if (lv == 0) begin : gLeaf
      assign node = truthTable;
    end else begin : gMux
      for (genvar j = 0; j < W; j++) begin : gNode
        assign node[j] = strobe.selLines[lv-1] ? gLevel[lv-1].node[2*j+1]
                                               : gLevel[lv-1].node[2*j];
      end
    end
  end

  assign fracTaps = gLevel[FRAC_LEVEL].node;
  assign fullOut  = gLevel[LUT_INPUTS].node[0];

  // dual mode must present all-ones on the forced select lines (R4)
  always_comb begin
    if (strobe.dualMode) begin
      assert_forced_sel_R4: assert (&strobe.selLines[LUT_INPUTS-1:FRAC_LEVEL])
        else $error("forced select line low in dual mode");
    end
  end
endmodule

// File: rtl/lut6_frac.sv
module lut6_frac
  import lut6_frac_pkg::*;
(
  input  logic [LUT_INPUTS-1:0] lutIn,
  input  logic [LEAVES-1:0]     truthTable,
  input  logic                  modeSel,
  output logic [TAPS-1:0]       lut5Out,
  output logic                  lut6Out
);
  lut_strobe_t strobe;

  lut_mode_ctrl u_ctrl (
    .lutIn   (lutIn),
    .modeSel (modeSel),
    .strobe  (strobe)
  );

  lut_mux_tree u_tree (
    .truthTable (truthTable),
    .strobe     (strobe),
    .fracTaps   (lut5Out),
    .fullOut    (lut6Out)
  );

  // port-level relations between outputs and the table
  always_comb begin
    for (int t = 0; t < TAPS; t++) begin
      assert_tap_value_R2: assert (lut5Out[t] ==
          truthTable[t * (1 << FRAC_LEVEL) + int'(lutIn[FRAC_LEVEL-1:0])])
        else $error("fractured output %0d wrong", t);
    end
    if (modeSel) begin
      assert_dual_root_R4: assert (lut6Out == lut5Out[TAPS-1])
        else $error("root differs from upper tap in dual mode");
    end else begin
      assert_full_value_R1: assert (lut6Out == truthTable[lutIn])
        else $error("root wrong in single mode");
      assert_top_select_R5: assert (lut6Out ==
          lut5Out[lutIn[LUT_INPUTS-1:FRAC_LEVEL]])
        else $error("top input does not pick the tap");
    end
  end
endmodule

// File: tb/sim_lut6_frac.sv
module sim_lut6_frac;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic [5:0]  lutIn = '0;
  logic [63:0] truthTable = '0;
  logic        modeSel = 1'b0;
  logic [1:0]  lut5Out;
  logic        lut6Out;

  lut6_frac u0 (
    .lutIn      (lutIn),
    .truthTable (truthTable),
    .modeSel    (modeSel),
    .lut5Out    (lut5Out),
    .lut6Out    (lut6Out)
  );

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 0;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      misses++;
      $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
      report();
    end
  end

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: in=%0d mode=%0b actual=%0b expected=%0b",
               tag, lutIn, modeSel, act, exp);
    end
  endtask

  // behavioural reference: table lookup by address
  task automatic apply(logic [63:0] tbl, logic mode, int idx);
    int low;
    logic e0, e1, e6;
    @(posedge clk);
    #1;
    truthTable = tbl;
    modeSel    = mode;
    lutIn      = 6'(idx);
    low = idx % 32;
    e0  = tbl[low];
    e1  = tbl[32 + low];
    e6  = mode ? e1 : tbl[idx];
    @(negedge clk); // R6: same cycle, no register on the path
    check("R2 lut5Out[0]", lut5Out[0], e0);
    check("R3 lut5Out[1]", lut5Out[1], e1);
    if (mode) check("R4 lut6Out dual", lut6Out, e6);
    else if (idx >= 32) check("R1 R5 lut6Out upper", lut6Out, e6);
    else check("R1 R5 R6 lut6Out lower", lut6Out, e6);
  endtask

  initial begin
    logic [63:0] tables [6];
    tables[0] = 64'h0;
    tables[1] = ~64'h0;
    tables[2] = 64'h0000_0000_FFFF_FFFF;
    tables[3] = 64'h1;
    tables[4] = {$urandom, $urandom};
    tables[5] = {$urandom, $urandom};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero inputs and zero table give zero outputs
    check("R1 reset lut6Out", lut6Out, 1'b0);
    check("R2 reset lut5Out[0]", lut5Out[0], 1'b0);
    check("R3 reset lut5Out[1]", lut5Out[1], 1'b0);
    rst = 1'b0;

    for (int t = 0; t < 6; t++) begin
      for (int m = 0; m < 2; m++) begin
        for (int i = 0; i < 64; i++) apply(tables[t], m[0], i);
      end
    end
    // R4: toggle the top input in dual mode at fixed low address
    for (int i = 0; i < 32; i++) begin
      apply(tables[4], 1'b1, i);
      apply(tables[4], 1'b1, i + 32);
    end
    // one-hot walk over every leaf in single mode
    for (int b = 0; b < 64; b++) apply(64'h1 << b, 1'b0, b);

    done = 1;
    report();
  end
endmodule